// File: doc/BRIEF.md
# Dual-Mode Transition Controller

This block decides which of two serial protocols a small serial memory answers on. After power-up the memory streams its contents in transmit-only mode, clocked by a dedicated transmit clock. A falling edge on the two-wire bus clock moves the block into a transition state. In that state it looks for the memory's control byte after a START condition. It also counts transmit-clock pulses as a timeout.

If the control byte arrives, the block commits to bidirectional slave mode for good. Only a power-on reset undoes that. If the timeout expires while the bus clock idles high, the block returns to transmit-only mode. It then pulses a restart so that the streamer starts again from the MSB of address 00h. In bidirectional mode the transmit clock no longer affects the mode, and its high level serves only as a write-enable qualifier.

All three inputs are synchronized to the system clock. Every edge is taken from the synchronized values.

Top module: `dual_mode_ctl`

## Requirements
- R1: After reset both `mode_trans_o` and `mode_bidi_o` are low (transmit-only mode), and `stream_restart_o` and `wr_en_o` are low.
- R2: In transmit-only mode, a high-to-low transition on `scl_i` raises `mode_trans_o`.
- R3: In the transition state, exactly 128 rising edges of `vclk_i` with `scl_i` high return the block to transmit-only mode with a single-cycle `stream_restart_o` pulse. After 127 edges it is still in the transition state.
- R4: Every high-to-low transition of `scl_i` in the transition state clears the pulse count, so a full 128 further edges are then needed.
- R5: If the count reaches 128 while `scl_i` is low, the block waits in the transition state. It falls back once `scl_i` is high again.
- R6: In the transition state, a byte whose first seven bits are 1010000, sent MSB first after a START (`sda_i` falling while `scl_i` is high) with bits sampled on `scl_i` rising, raises `mode_bidi_o` and lowers `mode_trans_o`. The eighth (read/write) bit may be 0 or 1.
- R7: A byte after START whose first seven bits differ from 1010000 leaves the block in the transition state.
- R8: Bidirectional mode is sticky. Any `vclk_i` pulses, `scl_i` edges or bytes leave `mode_bidi_o` high and `stream_restart_o` low, until `rst_ni` is asserted.
- R9: `wr_en_o` is high only when the block is in bidirectional mode and `vclk_i` is high.
- R10: After a fallback to transmit-only mode, a later falling edge on `scl_i` enters the transition state again.
- R11: Eight bits clocked in without a preceding START are not taken as a control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| scl_i | input | 1 | Two-wire bus clock (asynchronous) |
| sda_i | input | 1 | Two-wire bus data, input side (asynchronous) |
| vclk_i | input | 1 | Transmit-only clock (asynchronous) |
| mode_trans_o | output | 1 | Transition state active |
| mode_bidi_o | output | 1 | Bidirectional mode latched |
| stream_restart_o | output | 1 | One-cycle pulse: restart streaming at address 00h MSB |
| wr_en_o | output | 1 | Write-enable qualifier |

## Verification
An input edge reaches the synchronized level two system clocks after it is driven. Entry into the transition state and `wr_en_o` respond within three clocks. A control-byte match or a timeout expiry changes the mode by the fourth clock. The bench holds each input level for at least three clocks and samples the outputs on the falling clock edge, five or more clocks after the last edge that could matter. A free-running monitor on the falling edge counts restart pulses, so that a pulse's width and its count can be checked independently. The random phase replays scl blips and runs of vclk pulses through a bench model of the count and the mode, and compares after every operation once the pipeline has settled.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    MODE_TXO   = 2'd0,
    MODE_TRANS = 2'd1,
    MODE_BIDI  = 2'd2
  } mode_e;

  localparam int unsigned ID_W = 7;
endpackage

// File: rtl/dmc_sync.sv
module dmc_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] raw_i,
  input  logic [WIDTH-1:0] rst_val_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] last_o
);
  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= rst_val_i;
      last_q <= rst_val_i;
    end else begin
      stg_q[0] <= raw_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      last_q <= stg_q[STAGES-1];
    end
  end

  assign level_o = stg_q[STAGES-1];
  assign last_o  = last_q;
endmodule

// File: rtl/dmc_ctrl_det.sv
module dmc_ctrl_det
  import dmc_pkg::*;
#(
  parameter logic [ID_W-1:0] CTRL_ID = 7'h50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_hi_i,
  input  logic scl_rise_i,
  input  logic sda_hi_i,
  input  logic sda_fall_i,
  input  logic sda_rise_i,
  output logic match_o
);
  localparam int unsigned BIT_W = $clog2(ID_W + 1);

  logic             busy_q;
  logic [BIT_W-1:0] bit_q;
  logic [ID_W-1:0]  shr_q;
  logic             match_q;
  logic             start_c, stop_c;

  assign start_c = sda_fall_i & scl_hi_i;
  assign stop_c  = sda_rise_i & scl_hi_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      bit_q   <= '0;
      shr_q   <= '0;
      match_q <= 1'b0;
    end else begin
      match_q <= 1'b0;
      if (start_c) begin
        busy_q <= 1'b1;
        bit_q  <= '0;
      end else if (stop_c) begin
        busy_q <= 1'b0;
      end else if (busy_q && scl_rise_i) begin
        if (bit_q == BIT_W'(ID_W)) begin
          // read/write bit: address already complete
          busy_q  <= 1'b0;
          match_q <= (shr_q == CTRL_ID);
        end else begin
          shr_q <= {shr_q[ID_W-2:0], sda_hi_i};
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  assign match_o = match_q;
endmodule

// File: rtl/dmc_timeout.sv
module dmc_timeout #(
  parameter int unsigned LIMIT = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic clr_i,
  input  logic tick_i,
  input  logic idle_i,
  output logic expire_o
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!active_i || clr_i) cnt_q <= '0;
    else if (tick_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  // saturated count waits for the bus clock to idle high
  assign expire_o = active_i & (cnt_q == CNT_MAX) & idle_i;
endmodule

// File: rtl/dual_mode_ctl.sv
module dual_mode_ctl
  import dmc_pkg::*;
#(
  parameter int unsigned     SYNC_STAGES    = 2,
  parameter int unsigned     TIMEOUT_PULSES = 128,
  parameter logic [ID_W-1:0] CTRL_ID        = 7'h50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic vclk_i,
  output logic mode_trans_o,
  output logic mode_bidi_o,
  output logic stream_restart_o,
  output logic wr_en_o
);
  localparam int unsigned N_IN = 3;
  localparam int unsigned I_SCL = 0, I_SDA = 1, I_VCLK = 2;

  logic [N_IN-1:0] lvl, last;
  logic scl_fall, scl_rise, sda_fall, sda_rise, vclk_rise;
  logic match, expire;
  mode_e mode_q, mode_d;
  logic  restart_q;

  dmc_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raw_i     ({vclk_i, sda_i, scl_i}),
    .rst_val_i ({1'b0, 1'b1, 1'b1}),
    .level_o   (lvl),
    .last_o    (last)
  );

  assign scl_fall  =  last[I_SCL]  & ~lvl[I_SCL];
  assign scl_rise  = ~last[I_SCL]  &  lvl[I_SCL];
  assign sda_fall  =  last[I_SDA]  & ~lvl[I_SDA];
  assign sda_rise  = ~last[I_SDA]  &  lvl[I_SDA];
  assign vclk_rise = ~last[I_VCLK] &  lvl[I_VCLK];

  dmc_ctrl_det #(.CTRL_ID(CTRL_ID)) u_det (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_hi_i   (lvl[I_SCL]),
    .scl_rise_i (scl_rise),
    .sda_hi_i   (lvl[I_SDA]),
    .sda_fall_i (sda_fall),
    .sda_rise_i (sda_rise),
    .match_o    (match)
  );

  dmc_timeout #(.LIMIT(TIMEOUT_PULSES)) u_to (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (mode_q == MODE_TRANS),
    .clr_i    (scl_fall),
    .tick_i   (vclk_rise),
    .idle_i   (lvl[I_SCL]),
    .expire_o (expire)
  );

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_TXO:   if (scl_fall) mode_d = MODE_TRANS;
      MODE_TRANS: begin
        if (match)       mode_d = MODE_BIDI;
        else if (expire) mode_d = MODE_TXO;
      end
      MODE_BIDI:  mode_d = MODE_BIDI;
      default:    mode_d = MODE_TXO;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_TXO;
      restart_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      restart_q <= (mode_q == MODE_TRANS) && (mode_d == MODE_TXO);
    end
  end

  assign mode_trans_o     = (mode_q == MODE_TRANS);
  assign mode_bidi_o      = (mode_q == MODE_BIDI);
  assign stream_restart_o = restart_q;
  assign wr_en_o          = (mode_q == MODE_BIDI) & lvl[I_VCLK];
endmodule

// File: rtl/dual_mode_ctl_chk.sv
module dual_mode_ctl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic mode_trans_o,
  input logic mode_bidi_o,
  input logic stream_restart_o,
  input logic wr_en_o
);
  assert_mode_excl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mode_trans_o && mode_bidi_o));

  assert_enter_from_txo_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_trans_o) |-> $past(!mode_bidi_o));

  assert_restart_after_trans_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stream_restart_o |-> (!mode_trans_o && !mode_bidi_o && $past(mode_trans_o)));

  assert_restart_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stream_restart_o |=> !stream_restart_o);

  assert_bidi_from_trans_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_bidi_o) |-> $past(mode_trans_o));

  assert_bidi_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_bidi_o |=> (mode_bidi_o && !stream_restart_o));

  assert_wr_only_bidi_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> mode_bidi_o);
endmodule

bind dual_mode_ctl dual_mode_ctl_chk u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .mode_trans_o     (mode_trans_o),
  .mode_bidi_o      (mode_bidi_o),
  .stream_restart_o (stream_restart_o),
  .wr_en_o          (wr_en_o)
);

// File: tb/sim_dual_mode_ctl.sv
`timescale 1ns/1ps
module sim_dual_mode_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, vclk = 1'b0;
  logic trans, bidi, restart, wr_en;
  int   n_chk = 0, n_bad = 0, n_rst = 0;

  // model state for the random phase
  int m_mode = 0;
  int m_cnt  = 0;
  int m_rst  = 0;

  always #4 clk = ~clk;

  dual_mode_ctl u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda), .vclk_i(vclk),
    .mode_trans_o(trans), .mode_bidi_o(bidi),
    .stream_restart_o(restart), .wr_en_o(wr_en)
  );

  always @(negedge clk) if (restart) n_rst++;

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_lines(input logic s, input logic d, input logic v, input int hold);
    @(negedge clk);
    scl = s; sda = d; vclk = v;
    wait_n(hold);
  endtask

  task automatic vpulses(input int n);
    for (int i = 0; i < n; i++) begin
      set_lines(scl, sda, 1'b1, 3);
      set_lines(scl, sda, 1'b0, 3);
    end
    wait_n(2);
  endtask

  task automatic scl_blip();
    set_lines(1'b0, sda, vclk, 4);
    set_lines(1'b1, sda, vclk, 4);
    wait_n(2);
  endtask

  task automatic send_byte(input logic [7:0] b);
    set_lines(1'b1, 1'b0, vclk, 4);              // START
    set_lines(1'b0, 1'b0, vclk, 4);
    for (int i = 7; i >= 0; i--) begin
      set_lines(1'b0, b[i], vclk, 3);
      set_lines(1'b1, b[i], vclk, 4);
      set_lines(1'b0, b[i], vclk, 3);
    end
    set_lines(1'b0, 1'b0, vclk, 3);
    set_lines(1'b1, 1'b0, vclk, 4);
    set_lines(1'b1, 1'b1, vclk, 6);              // STOP
  endtask

  task automatic send_raw(input logic [7:0] b);
    set_lines(1'b0, 1'b1, vclk, 4);
    for (int i = 7; i >= 0; i--) begin
      set_lines(1'b0, b[i], vclk, 3);
      set_lines(1'b1, b[i], vclk, 4);
      set_lines(1'b0, b[i], vclk, 3);
    end
    set_lines(1'b0, 1'b1, vclk, 3);
    set_lines(1'b1, 1'b1, vclk, 6);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; scl = 1'b1; sda = 1'b1; vclk = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(3);
  endtask

  // expected mode code: 0 txo, 1 trans, 2 bidi
  function automatic int mode_code(input logic t, input logic b);
    return b ? 2 : (t ? 1 : 0);
  endfunction

  function automatic int model_pulse_mode(input int mode, input int cnt);
    return (mode == 1 && cnt + 1 >= 128) ? 0 : mode;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int base;
    do_reset();
    check(trans, 0, "R1 trans");
    check(bidi, 0, "R1 bidi");
    check(wr_en, 0, "R1 wr_en");
    check(n_rst, 0, "R1 restart");

    vpulses(5);
    set_lines(1'b1, 1'b1, 1'b1, 6);
    check(wr_en, 0, "R9 wr_en in txo");
    set_lines(1'b1, 1'b1, 1'b0, 3);

    scl_blip();
    check(trans, 1, "R2 enter trans");

    vpulses(127);
    check(trans, 1, "R3 after 127");
    vpulses(1);
    check(trans, 0, "R3 after 128");
    check(n_rst, 1, "R3 restart count");

    scl_blip();
    check(trans, 1, "R10 reenter");

    vpulses(100);
    scl_blip();
    vpulses(100);
    check(trans, 1, "R4 cleared count");
    vpulses(28);
    check(trans, 0, "R4 full count after clear");
    check(n_rst, 2, "R4 restart count");

    // R5: saturate while scl low
    set_lines(1'b0, 1'b1, 1'b0, 4);
    vpulses(130);
    check(trans, 1, "R5 wait while scl low");
    check(n_rst, 2, "R5 no restart yet");
    set_lines(1'b1, 1'b1, 1'b0, 6);
    check(trans, 0, "R5 fallback on idle");
    check(n_rst, 3, "R5 restart");

    send_raw(8'hA0);
    check(trans, 1, "R11 raw bits enter trans");
    check(bidi, 0, "R11 no start no match");

    send_byte(8'hA2);
    check(bidi, 0, "R7 wrong id");
    check(trans, 1, "R7 stays trans");

    send_byte(8'hA1);
    check(bidi, 1, "R6 read bit id");
    check(trans, 0, "R6 trans cleared");

    base = n_rst;
    vpulses(300);
    scl_blip();
    send_byte(8'h3C);
    check(bidi, 1, "R8 sticky");
    check(n_rst, base, "R8 no restart");

    set_lines(1'b1, 1'b1, 1'b1, 5);
    check(wr_en, 1, "R9 wr_en high");
    set_lines(1'b1, 1'b1, 1'b0, 5);
    check(wr_en, 0, "R9 wr_en low");

    do_reset();
    check(bidi, 0, "R8 reset clears bidi");
    send_byte(8'hA0);
    check(bidi, 1, "R6 write bit id");

    // random phase
    do_reset();
    void'($urandom(32'h5eed_0042));
    m_mode = 0; m_cnt = 0; m_rst = n_rst;
    for (int it = 0; it < 40; it++) begin
      if ($urandom % 3 == 0) begin
        scl_blip();
        if (m_mode == 0) m_mode = 1;
        m_cnt = 0;
      end else begin
        int n = $urandom_range(1, 140);
        vpulses(n);
        for (int k = 0; k < n; k++) begin
          if (m_mode == 1) begin
            if (model_pulse_mode(m_mode, m_cnt) == 0) begin
              m_mode = 0; m_cnt = 0; m_rst++;
            end else m_cnt++;
          end
        end
      end
      check(mode_code(trans, bidi), m_mode, "R3 R4 random mode");
      check(n_rst, m_rst, "R3 random restarts");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule